// File: doc/BRIEF.md
# Number-Class Sequence Display Controller

This block plays a fixed sequence of single decimal digits, grouped into three classes. It shows them on two seven-segment digits and on an 8-bit LED bank. The primes come first (2, 3, 5, 7), then the even digits (0, 2, 4, 6, 8), then the odd digits (1, 3, 5, 7, 9). After the last odd digit the sequence starts again with the primes. Within each class the values rise in ascending order.

The left digit shows a letter for the current class: P, E or O. The right digit shows the current value. The LED bank carries the same value in binary.

The sequence moves forward one step only on a clock cycle where the step enable input is high. An external tick source therefore sets how long each value stays on the display. A one-cycle strobe marks every change of class letter.

Top module: `numclass_disp`

## Requirements
- R1: While reset is asserted and after it is released, the block shows the prime class (left code 7'h0C), the value 2 on the right digit (7'h24) and LED value 8'd2, with the strobe low.
- R2: On a cycle where step_en is low, no output changes.
- R3: The prime phase shows left code 7'h0C (P lit on a,b,e,f,g) and steps through 2, 3, 5, 7.
- R4: The even phase shows left code 7'h06 (E lit on a,d,e,f,g) and steps through 0, 2, 4, 6, 8.
- R5: The odd phase shows left code 7'h40 (O, the same as digit 0) and steps through 1, 3, 5, 7, 9.
- R6: A step taken while the odd value 9 is shown returns the block to the prime phase with value 2.
- R7: led_value equals the binary value of the digit on the right display, so its upper four bits are always zero.
- R8: The segment codes are active-low, with bit order {g,f,e,d,c,b,a}. The digit codes for 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10 (hex).
- R9: phase_chg is high for exactly one cycle, the first cycle in which a new class letter is shown, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advance the sequence by one value on this cycle |
| seg_class | output | 7 | Left digit, class letter, active-low {g,f,e,d,c,b,a} |
| seg_value | output | 7 | Right digit, current value, active-low {g,f,e,d,c,b,a} |
| led_value | output | 8 | Binary value of the right digit |
| phase_chg | output | 1 | One-cycle strobe when the class letter changes |

## Verification
The hardest situation to reach from the ports is the wrap from the last odd value back to the first prime. It appears only after fourteen separate steps, each with a tick, and it must raise the strobe for a single cycle. The stimulus table walks the whole cycle one step at a time, so every phase boundary is seen, including the wrap. Directed tests then hold step_en low across a boundary and apply reset partway through a phase.

// File: rtl/numclass_pkg.sv
package numclass_pkg;

  typedef enum logic [1:0] {
    PH_PRIME = 2'd0,
    PH_EVEN  = 2'd1,
    PH_ODD   = 2'd2
  } phase_t;

  localparam int unsigned IDX_W   = 3;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned GLYPH_W = 4;

  // Glyph codes 0..9 are digits; letters follow.
  localparam logic [GLYPH_W-1:0] GL_P = 4'd10;
  localparam logic [GLYPH_W-1:0] GL_E = 4'd11;
  localparam logic [GLYPH_W-1:0] GL_O = 4'd12;

  function automatic logic [IDX_W-1:0] last_idx(input phase_t ph);
    return (ph == PH_PRIME) ? IDX_W'(3) : IDX_W'(4);
  endfunction

  function automatic phase_t next_phase(input phase_t ph);
    case (ph)
      PH_PRIME: return PH_EVEN;
      PH_EVEN:  return PH_ODD;
      default:  return PH_PRIME;
    endcase
  endfunction

  function automatic logic [GLYPH_W-1:0] class_glyph(input phase_t ph);
    case (ph)
      PH_PRIME: return GL_P;
      PH_EVEN:  return GL_E;
      default:  return GL_O;
    endcase
  endfunction

endpackage

// File: rtl/numclass_seq.sv
module numclass_seq
  import numclass_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             chg
);

  phase_t           ph_q, ph_d;
  logic [IDX_W-1:0] ix_q, ix_d;
  logic             chg_q, chg_d;

  always_comb begin
    ph_d  = ph_q;
    ix_d  = ix_q;
    chg_d = 1'b0;
    if (step_en) begin
      if (ix_q == last_idx(ph_q)) begin
        ph_d  = next_phase(ph_q);
        ix_d  = '0;
        chg_d = 1'b1;
      end else begin
        ix_d = ix_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PRIME;
      ix_q  <= '0;
      chg_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ix_q  <= ix_d;
      chg_q <= chg_d;
    end
  end

  assign phase = ph_q;
  assign idx   = ix_q;
  assign chg   = chg_q;

endmodule

// File: rtl/numclass_digit.sv
module numclass_digit
  import numclass_pkg::*;
(
  input  phase_t             phase,
  input  logic [IDX_W-1:0]   idx,
  output logic [DIGIT_W-1:0] digit
);

  always_comb begin
    case (phase)
      PH_PRIME: begin
        case (idx)
          3'd0:    digit = 4'd2;
          3'd1:    digit = 4'd3;
          3'd2:    digit = 4'd5;
          default: digit = 4'd7;
        endcase
      end
      PH_EVEN: digit = {idx, 1'b0};
      default: digit = {idx, 1'b1};
    endcase
  end

endmodule

// File: rtl/numclass_glyph.sv
module numclass_glyph
  import numclass_pkg::*;
#(
  parameter int unsigned SEG_W      = 7,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic [GLYPH_W-1:0] glyph,
  output logic [SEG_W-1:0]   seg
);

  logic [6:0] lit;  // active-high {g,f,e,d,c,b,a}

  always_comb begin
    case (glyph)
      4'd0:    lit = 7'h3F;
      4'd1:    lit = 7'h06;
      4'd2:    lit = 7'h5B;
      4'd3:    lit = 7'h4F;
      4'd4:    lit = 7'h66;
      4'd5:    lit = 7'h6D;
      4'd6:    lit = 7'h7D;
      4'd7:    lit = 7'h07;
      4'd8:    lit = 7'h7F;
      4'd9:    lit = 7'h6F;
      GL_P:    lit = 7'h73;
      GL_E:    lit = 7'h79;
      GL_O:    lit = 7'h3F;
      default: lit = 7'h00;
    endcase
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = SEG_W'(~lit);
    end else begin : g_high
      assign seg = SEG_W'(lit);
    end
  endgenerate

endmodule

// File: rtl/numclass_disp.sv
module numclass_disp
  import numclass_pkg::*;
#(
  parameter int unsigned SEG_W = 7,
  parameter int unsigned LED_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [SEG_W-1:0] seg_class,
  output logic [SEG_W-1:0] seg_value,
  output logic [LED_W-1:0] led_value,
  output logic             phase_chg
);

  localparam int unsigned PAD_W = LED_W - DIGIT_W;

  phase_t             phase;
  logic [IDX_W-1:0]   idx;
  logic [DIGIT_W-1:0] digit;

  numclass_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .phase   (phase),
    .idx     (idx),
    .chg     (phase_chg)
  );

  numclass_digit dig_i (
    .phase (phase),
    .idx   (idx),
    .digit (digit)
  );

  numclass_glyph #(.SEG_W(SEG_W), .ACTIVE_LOW(1'b1)) cls_glyph_i (
    .glyph (class_glyph(phase)),
    .seg   (seg_class)
  );

  numclass_glyph #(.SEG_W(SEG_W), .ACTIVE_LOW(1'b1)) val_glyph_i (
    .glyph (digit),
    .seg   (seg_value)
  );

  assign led_value = {{PAD_W{1'b0}}, digit};

endmodule

// File: rtl/numclass_disp_chk.sv
module numclass_disp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_en,
  input logic [6:0] seg_class,
  input logic [6:0] seg_value,
  input logic [7:0] led_value,
  input logic       phase_chg
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(seg_value) && $stable(seg_class) && $stable(led_value)));

  a_r7_led_digit: assert property (@(posedge clk) disable iff (!rst_n)
    led_value <= 8'd9);

  a_r3_prime_values: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_class == 7'h0C) |-> (led_value == 8'd2 || led_value == 8'd3 ||
                              led_value == 8'd5 || led_value == 8'd7));

  a_r6_wrap_to_two: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_chg && seg_class == 7'h0C) |-> (led_value == 8'd2));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |=> !phase_chg);

  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_class != $past(seg_class)) |-> phase_chg);

  a_r9_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg |-> (seg_class != $past(seg_class)));

endmodule

bind numclass_disp numclass_disp_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .seg_class (seg_class),
  .seg_value (seg_value),
  .led_value (led_value),
  .phase_chg (phase_chg)
);

// File: tb/numclass_disp_tb_top.sv
module numclass_disp_tb_top;

  logic       clk;
  logic       rst_n;
  logic       step_en;
  logic [6:0] seg_class;
  logic [6:0] seg_value;
  logic [7:0] led_value;
  logic       phase_chg;

  int n_checks = 0;
  int n_errors = 0;

  numclass_disp dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .seg_class (seg_class),
    .seg_value (seg_value),
    .led_value (led_value),
    .phase_chg (phase_chg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [6:0] C_P = 7'h0C;
  localparam logic [6:0] C_E = 7'h06;
  localparam logic [6:0] C_O = 7'h40;

  // Per step: {class code, value segments, led value, strobe}
  localparam int NSTEP = 14;
  localparam logic [22:0] VEC [NSTEP] = '{
    {C_P, 7'h30, 8'd3, 1'b0},
    {C_P, 7'h12, 8'd5, 1'b0},
    {C_P, 7'h78, 8'd7, 1'b0},
    {C_E, 7'h40, 8'd0, 1'b1},
    {C_E, 7'h24, 8'd2, 1'b0},
    {C_E, 7'h19, 8'd4, 1'b0},
    {C_E, 7'h02, 8'd6, 1'b0},
    {C_E, 7'h00, 8'd8, 1'b0},
    {C_O, 7'h79, 8'd1, 1'b1},
    {C_O, 7'h30, 8'd3, 1'b0},
    {C_O, 7'h12, 8'd5, 1'b0},
    {C_O, 7'h78, 8'd7, 1'b0},
    {C_O, 7'h10, 8'd9, 1'b1 & 1'b0},
    {C_P, 7'h24, 8'd2, 1'b1}
  };

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got cls=%h seg=%h led=%0d chg=%b, expected cls=%h seg=%h led=%0d chg=%b",
               req, act[22:16], act[15:9], act[8:1], act[0],
               exp[22:16], exp[15:9], exp[8:1], exp[0]);
    end
  endtask

  function automatic logic [22:0] obs();
    return {seg_class, seg_value, led_value, phase_chg};
  endfunction

  task automatic step1();
    @(negedge clk) step_en = 1'b1;
    @(negedge clk) step_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic string req_of(input int i);
    if (i < 3)       return "R3";
    else if (i < 8)  return "R4";
    else if (i < 13) return "R5";
    else             return "R6";
  endfunction

  initial begin
    fork
      begin
        step_en = 1'b0;
        rst_n   = 1'b0;
        idle(2);
        check("R1 during reset", obs(), {C_P, 7'h24, 8'd2, 1'b0});
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", obs(), {C_P, 7'h24, 8'd2, 1'b0});

        // Full cycle through all three phases and the wrap (R7, R8 via codes)
        for (int i = 0; i < NSTEP; i++) begin
          step1();
          check(req_of(i), obs(), VEC[i]);
        end

        // R9: strobe gone one cycle after the wrap
        idle(1);
        check("R9 strobe one cycle", obs(), {C_P, 7'h24, 8'd2, 1'b0});

        // R2: hold across a phase boundary with step_en low
        step1(); step1(); step1();
        check("R3 at last prime", obs(), {C_P, 7'h78, 8'd7, 1'b0});
        idle(6);
        check("R2 hold at boundary", obs(), {C_P, 7'h78, 8'd7, 1'b0});
        step1();
        check("R4 cross after hold", obs(), {C_E, 7'h40, 8'd0, 1'b1});

        // R2: multi-cycle step_en advances one value per cycle
        @(negedge clk) step_en = 1'b1;
        @(negedge clk);
        check("R4 back-to-back 1", obs(), {C_E, 7'h24, 8'd2, 1'b0});
        @(negedge clk) step_en = 1'b0;
        check("R7 back-to-back 2", obs(), {C_E, 7'h19, 8'd4, 1'b0});

        // R1: reset partway through a phase
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        check("R1 mid-phase reset", obs(), {C_P, 7'h24, 8'd2, 1'b0});
        step1();
        check("R8 digit 3 after reset", obs(), {C_P, 7'h30, 8'd3, 1'b0});
      end
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule